// File: doc/BRIEF.md
# Dual-Channel Output Compare Timer

This block is a 16-bit up-counter with two compare channels, programmed through a byte-wide register port. A two-bit field picks the counting rate: the system clock divided by 2, 4 or 8, or a one-cycle tick pulse from outside the block. Each channel holds a 16-bit compare value, split into a high byte register and a low byte register. When the counter reaches a channel's value, the channel sets its status flag and, if its pin is enabled, loads a programmed level into its pin latch. The interrupt line is raised while any flag is set and interrupts are enabled.

Software can also load a level into a pin latch directly through a force bit. A forced load sets no flag and raises no interrupt. The force bits do nothing while either of the two waveform-mode bits (single pulse or pulse-width) is set. Writing a high compare byte suspends that channel's comparison until its low byte is written.

A build-time option turns the second channel's compare registers into write-only storage and keeps that channel from ever producing a match. All register accesses are single-cycle strobes with no wait states. The block has no streaming data path, so it has no valid/ready handshake.

Top module: `ocmp_timer`

## Requirements
- R1: While reset is held and just after it is released, `count` is 0xFFFC, `irq` is 0, both pin latches are 0 and both pin enables are 0. Registers 0, 1 and 2 read back as 0.
- R2: `count` goes up by exactly one per tick and wraps from 0xFFFF to 0x0000. The clock-select field (register 0 bits [1:0]) gives these tick rates: 00 is every 2 cycles, 01 every 4, 10 every 8, and 11 is every cycle in which `ext_tick` is 1.
- R3: With select 00 or 01, a channel's flag becomes visible in the first cycle in which `count` equals its compare value.
- R4: With select 10 or 11, the flag becomes visible in the first cycle in which `count` equals the compare value plus one, taken modulo 2^16. A compare value of 0xFFFF therefore matches at 0x0000.
- R5: A write to a channel's high byte suspends that channel's matching until its low byte is next written. After reset, a channel stays suspended until its first low-byte write.
- R6: On a match, if the channel's enable bit (register 1 bit 0 for channel 1, bit 1 for channel 2) is 1, the pin latch loads that channel's level bit (register 0 bit 5 or bit 6). If the enable bit is 0, the latch keeps its value but the flag still sets. `cmp_pin_en` mirrors the enable bits.
- R7: `irq` is 1 exactly when the enable bit in register 0 bit 2 is 1 and at least one flag is set. A flag sets whether or not interrupts are enabled.
- R8: A flag is cleared only by this sequence: a read of the status register (register 2; bit 0 is channel 1, bit 1 is channel 2) that sees the flag set, followed by a read or write of that channel's low byte. A low-byte access without the earlier status read leaves the flag set.
- R9: Writing register 0 with force bit 3 (channel 1) or bit 4 (channel 2) set loads the level bit from the same write into that pin latch, visible on the next cycle. It does not touch the other pin, sets no flag and raises no `irq`. Force bits read back as 0.
- R10: While register 1 bit 2 (single-pulse mode) or bit 3 (pulse-width mode) is 1, the force bits have no effect on the pins.
- R11: With `CH2_WRITE_ONLY` set, the channel-2 compare bytes read as 0, channel 2's flag is always 0, and channel 1 behaves unchanged.
- R12: Register addresses: 0 is control A (select, irq enable, force, levels), 1 is control B (pin enables, mode bits), 2 is status, 3 and 4 are the channel-1 high and low bytes, 5 and 6 are the channel-2 high and low bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (status and low-byte reads have side effects) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational from address) |
| ext_tick | input | 1 | External count enable, one cycle per tick |
| count | output | 16 | Current counter value |
| cmp_pin | output | 2 | Pin latches, bit 0 is channel 1 |
| cmp_pin_en | output | 2 | Pin drive enables; when 0 the pin belongs to general I/O |
| irq | output | 1 | Interrupt request |

## Verification
The bench sweeps all four counting rates and both channels, with several compare distances in each. At every flag rise it checks the exact counter value, so a design that uses one match offset for every rate shows up as a count that is off by one. It also catches the compare-plus-one carry at the top of the range: a design that lost that carry would never match at 0x0000. It rewrites a high byte after the full value is armed and lets the counter run past the old value; a design without the suspend would fire at that point. It also checks that a low-byte access alone leaves a flag set, that forcing sets no flag, and that either mode bit blocks forcing. A wrong design would leave stray interrupts or clear status early.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;
  localparam int NCH = 2;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_CTLA = 3'd0,
    RA_CTLB = 3'd1,
    RA_STAT = 3'd2,
    RA_C1H  = 3'd3,
    RA_C1L  = 3'd4,
    RA_C2H  = 3'd5,
    RA_C2L  = 3'd6,
    RA_NONE = 3'd7
  } reg_addr_e;

  typedef enum logic [1:0] {
    CK_DIV2 = 2'b00,
    CK_DIV4 = 2'b01,
    CK_DIV8 = 2'b10,
    CK_EXT  = 2'b11
  } clk_sel_e;

  // control A bit positions
  localparam int CA_IRQEN = 2;
  localparam int CA_FRC0  = 3;
  localparam int CA_LVL0  = 5;
  // control B bit positions
  localparam int CB_OE0 = 0;
  localparam int CB_OPM = 2;
  localparam int CB_PWM = 3;

  typedef struct packed {
    logic [NCH-1:0] lvl;
    logic           irq_en;
    clk_sel_e       sel;
  } ctla_t;

  typedef struct packed {
    logic           pwm;
    logic           opm;
    logic [NCH-1:0] oe;
  } ctlb_t;

  // slow rates see the counter one step later
  function automatic logic late_match(clk_sel_e s);
    return (s == CK_DIV8) || (s == CK_EXT);
  endfunction

  function automatic logic [ADDR_W-1:0] cmp_hi_addr(int ch);
    return ADDR_W'(int'(RA_C1H) + 2 * ch);
  endfunction
endpackage

// File: rtl/ocmp_clkgen.sv
module ocmp_clkgen
  import ocmp_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter logic [CNT_W-1:0] RST_COUNT = {{(CNT_W-2){1'b1}}, 2'b00},
  parameter int PSC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  clk_sel_e         sel,
  input  logic             ext_tick,
  output logic [CNT_W-1:0] count,
  output logic             moved
);
  logic [PSC_W-1:0] psc;
  logic [PSC_W-1:0] mask;
  logic             tick;

  always_comb begin
    case (sel)
      CK_DIV2: mask = PSC_W'(1);
      CK_DIV4: mask = PSC_W'(3);
      CK_DIV8: mask = PSC_W'(7);
      default: mask = '0;
    endcase
  end

  assign tick = (sel == CK_EXT) ? ext_tick : ((psc & mask) == mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      psc   <= '0;
      count <= RST_COUNT;
      moved <= 1'b0;
    end else begin
      psc   <= psc + 1'b1;
      moved <= tick;
      if (tick) count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/ocmp_channel.sv
module ocmp_channel #(
  parameter int CNT_W = 16,
  parameter bit DISABLED = 1'b0,
  parameter logic [CNT_W-1:0] CMP_RST = '1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_hi,
  input  logic               wr_lo,
  input  logic               lo_touch,
  input  logic               stat_read,
  input  logic [CNT_W/2-1:0] wdata,
  input  logic [CNT_W-1:0]   count,
  input  logic               moved,
  input  logic               late,
  input  logic               oe,
  input  logic               lvl,
  input  logic               force_go,
  input  logic               force_lvl,
  output logic [CNT_W-1:0]   cmp,
  output logic               flag,
  output logic               pin
);
  localparam int BW = CNT_W / 2;

  logic             inhibit;
  logic             seen;
  logic             hit;
  logic [CNT_W-1:0] target;

  assign target = cmp + {{(CNT_W-1){1'b0}}, late};

  generate
    if (DISABLED) begin : g_off
      assign hit = 1'b0;
    end else begin : g_on
      assign hit = moved && !inhibit && (count == target);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp     <= CMP_RST;
      inhibit <= 1'b1;
      seen    <= 1'b0;
      flag    <= 1'b0;
      pin     <= 1'b0;
    end else begin
      if (wr_hi) begin
        cmp[CNT_W-1:BW] <= wdata;
        inhibit         <= 1'b1;
      end
      if (wr_lo) begin
        cmp[BW-1:0] <= wdata;
        inhibit     <= 1'b0;
      end
      if (stat_read && flag) seen <= 1'b1;
      else if (lo_touch)     seen <= 1'b0;
      if (hit)                   flag <= 1'b1;
      else if (lo_touch && seen) flag <= 1'b0;
      if (force_go)       pin <= force_lvl;
      else if (hit && oe) pin <= lvl;
    end
  end
endmodule

// File: rtl/ocmp_timer.sv
module ocmp_timer
  import ocmp_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter logic [CNT_W-1:0] RST_COUNT = {{(CNT_W-2){1'b1}}, 2'b00},
  parameter bit CH2_WRITE_ONLY = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [CNT_W/2-1:0]   reg_wdata,
  output logic [CNT_W/2-1:0]   reg_rdata,
  input  logic                 ext_tick,
  output logic [CNT_W-1:0]     count,
  output logic [NCH-1:0]       cmp_pin,
  output logic [NCH-1:0]       cmp_pin_en,
  output logic                 irq
);
  localparam int BW = CNT_W / 2;

  reg_addr_e ra;
  ctla_t     ctla;
  ctlb_t     ctlb;
  logic      moved;
  logic      late;
  logic      stat_read;
  logic      force_ok;
  logic      irq_en_w;

  logic [NCH-1:0] wr_hi, wr_lo, lo_touch, flag, force_go, force_lvl, oe_w;
  logic [CNT_W-1:0] cmp_v [NCH];

  assign ra        = reg_addr_e'(reg_addr);
  assign late      = late_match(ctla.sel);
  assign stat_read = reg_rd && (ra == RA_STAT);
  assign force_ok  = !ctlb.opm && !ctlb.pwm;
  assign irq_en_w  = ctla.irq_en;
  assign oe_w      = ctlb.oe;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctla <= '0;
      ctlb <= '0;
    end else if (reg_wr) begin
      if (ra == RA_CTLA) begin
        ctla.sel    <= clk_sel_e'(reg_wdata[1:0]);
        ctla.irq_en <= reg_wdata[CA_IRQEN];
        ctla.lvl    <= reg_wdata[CA_LVL0 +: NCH];
      end
      if (ra == RA_CTLB) begin
        ctlb.oe  <= reg_wdata[CB_OE0 +: NCH];
        ctlb.opm <= reg_wdata[CB_OPM];
        ctlb.pwm <= reg_wdata[CB_PWM];
      end
    end
  end

  ocmp_clkgen #(
    .CNT_W(CNT_W),
    .RST_COUNT(RST_COUNT)
  ) u_clkgen (
    .clk(clk),
    .rst_n(rst_n),
    .sel(ctla.sel),
    .ext_tick(ext_tick),
    .count(count),
    .moved(moved)
  );

  genvar i;
  generate
    for (i = 0; i < NCH; i++) begin : g_ch
      assign wr_hi[i]     = reg_wr && (reg_addr == cmp_hi_addr(i));
      assign wr_lo[i]     = reg_wr && (reg_addr == cmp_hi_addr(i) + 1'b1);
      assign lo_touch[i]  = (reg_wr || reg_rd) && (reg_addr == cmp_hi_addr(i) + 1'b1);
      assign force_go[i]  = reg_wr && (ra == RA_CTLA) && reg_wdata[CA_FRC0 + i] && force_ok;
      assign force_lvl[i] = reg_wdata[CA_LVL0 + i];

      ocmp_channel #(
        .CNT_W(CNT_W),
        .DISABLED((i == NCH - 1) && CH2_WRITE_ONLY)
      ) u_ch (
        .clk(clk),
        .rst_n(rst_n),
        .wr_hi(wr_hi[i]),
        .wr_lo(wr_lo[i]),
        .lo_touch(lo_touch[i]),
        .stat_read(stat_read),
        .wdata(reg_wdata),
        .count(count),
        .moved(moved),
        .late(late),
        .oe(oe_w[i]),
        .lvl(ctla.lvl[i]),
        .force_go(force_go[i]),
        .force_lvl(force_lvl[i]),
        .cmp(cmp_v[i]),
        .flag(flag[i]),
        .pin(cmp_pin[i])
      );
    end
  endgenerate

  always_comb begin
    reg_rdata = '0;
    case (ra)
      RA_CTLA: begin
        reg_rdata[1:0]               = ctla.sel;
        reg_rdata[CA_IRQEN]          = ctla.irq_en;
        reg_rdata[CA_LVL0 +: NCH]    = ctla.lvl;
      end
      RA_CTLB: begin
        reg_rdata[CB_OE0 +: NCH] = ctlb.oe;
        reg_rdata[CB_OPM]        = ctlb.opm;
        reg_rdata[CB_PWM]        = ctlb.pwm;
      end
      RA_STAT: reg_rdata[NCH-1:0] = flag;
      RA_C1H:  reg_rdata = cmp_v[0][CNT_W-1:BW];
      RA_C1L:  reg_rdata = cmp_v[0][BW-1:0];
      RA_C2H:  reg_rdata = CH2_WRITE_ONLY ? '0 : cmp_v[1][CNT_W-1:BW];
      RA_C2L:  reg_rdata = CH2_WRITE_ONLY ? '0 : cmp_v[1][BW-1:0];
      default: reg_rdata = '0;
    endcase
  end

  assign cmp_pin_en = oe_w;
  assign irq        = irq_en_w && (|flag);
endmodule

// File: rtl/ocmp_timer_chk.sv
module ocmp_timer_chk #(
  parameter int CNT_W = 16,
  parameter bit CH2_WRITE_ONLY = 1'b0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq,
  input logic             irq_en,
  input logic [1:0]       flags,
  input logic [1:0]       oe,
  input logic [1:0]       force_go,
  input logic [1:0]       pins,
  input logic [1:0]       lo_touch,
  input logic [CNT_W-1:0] count
);
  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(count) |-> count == $past(count) + 1'b1);

  p_irq_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);

  p_irq_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flags != 2'b00));

  genvar g;
  generate
    for (g = 0; g < 2; g++) begin : g_pc
      p_pin_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe[g] && !force_go[g]) |=> $stable(pins[g]));
      p_flag_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flags[g]) |-> $past(lo_touch[g]));
    end
    if (CH2_WRITE_ONLY) begin : g_wo
      p_ch2_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !flags[1]);
    end
  endgenerate
endmodule

bind ocmp_timer ocmp_timer_chk #(
  .CNT_W(CNT_W),
  .CH2_WRITE_ONLY(CH2_WRITE_ONLY)
) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .irq(irq),
  .irq_en(irq_en_w),
  .flags(flag),
  .oe(oe_w),
  .force_go(force_go),
  .pins(cmp_pin),
  .lo_touch(lo_touch),
  .count(count)
);

// File: tb/ocmp_timer_test.sv
module ocmp_timer_test;
  import ocmp_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic       ext_tick = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] rdata_a, rdata_b;
  logic [15:0] count_a, count_b;
  logic [1:0] pin_a, pin_b, en_a, en_b;
  logic       irq_a, irq_b;

  int total = 0;
  int bad = 0;
  int ph = 0;
  bit ext_run = 1'b0;

  always #10 clk = ~clk;

  ocmp_timer #(.CH2_WRITE_ONLY(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata_a),
    .ext_tick(ext_tick), .count(count_a), .cmp_pin(pin_a),
    .cmp_pin_en(en_a), .irq(irq_a)
  );

  ocmp_timer #(.CH2_WRITE_ONLY(1'b1)) uut_wo (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata_b),
    .ext_tick(ext_tick), .count(count_b), .cmp_pin(pin_b),
    .cmp_pin_en(en_b), .irq(irq_b)
  );

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] da, output logic [7:0] db);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1;
    da = rdata_a; db = rdata_b;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wait_irq(output bit seen);
    seen = 1'b0;
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      if (irq_a) begin
        seen = 1'b1;
        break;
      end
    end
  endtask

  task automatic measure(input int exp_gap);
    logic [15:0] prev;
    int n;
    prev = count_a;
    for (int w = 0; w < 20 && count_a == prev; w++) @(negedge clk);
    prev = count_a;
    n = 0;
    for (int w = 0; w < 20 && count_a == prev; w++) begin
      @(negedge clk);
      n++;
    end
    check("R2 tick spacing", n, exp_gap);
    check("R2 step of one", count_a, prev + 16'd1);
  endtask

  task automatic run_case(input int sel, input int ch, input int k);
    logic [7:0] a, b;
    logic [15:0] c, exp_cnt;
    logic lvl, oe, old;
    bit seen;
    lvl = 1'((k + ch) % 2);
    oe  = (k != 5);
    wr(RA_CTLA, {1'b0, lvl, lvl, 2'b00, 1'b1, 2'(sel)});
    wr(RA_CTLB, oe ? 8'(1 << ch) : 8'h00);
    old = pin_a[ch];
    c = count_a + 16'(k);
    wr(3'(3 + 2 * ch), c[15:8]);
    wr(3'(4 + 2 * ch), c[7:0]);
    wait_irq(seen);
    exp_cnt = (sel >= 2) ? c + 16'd1 : c;
    check(sel >= 2 ? "R4 match count" : "R3 match count", {15'd0, seen, count_a}, {15'd0, 1'b1, exp_cnt});
    check("R6 pin latch", pin_a[ch], oe ? lvl : old);
    check("R6 pin enable", en_a[ch], oe);
    check("R11 write-only irq", irq_b, (ch == 0));
    rd(RA_STAT, a, b);
    check("R8 status bit", a, 8'(1 << ch));
    rd(3'(4 + 2 * ch), a, b);
    rd(RA_STAT, a, b);
    check("R8 flag cleared", {a, 7'd0, irq_a}, 16'd0);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (ext_run) begin
        ph = (ph + 1) % 3;
        ext_tick = (ph == 0);
      end else begin
        ext_tick = 1'b0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog R2 act=timeout exp=complete");
    finish_run();
  end

  initial begin
    logic [7:0] a, b;
    logic [15:0] c, c2;
    bit seen;
    bit stray;

    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 count", count_a, 16'hFFFC);
    check("R1 irq/pins/enables", {irq_a, pin_a, en_a}, 5'd0);
    rst_n = 1'b1;
    rd(RA_CTLA, a, b); check("R1 ctla", a, 8'h00);
    rd(RA_CTLB, a, b); check("R1 ctlb", a, 8'h00);
    rd(RA_STAT, a, b); check("R1 stat", a, 8'h00);

    // R4 wrap: compare 0xFFFF at divide-by-8 matches at 0x0000
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    wr(RA_CTLA, 8'h66);
    wr(RA_CTLB, 8'h03);
    wr(RA_C1H, 8'hFF);
    wr(RA_C1L, 8'hFF);
    wait_irq(seen);
    check("R4 wrap match", {15'd0, seen, count_a}, {15'd0, 1'b1, 16'h0000});
    check("R6 level loaded", pin_a[0], 1'b1);
    check("R5 unarmed channel 2 idle", pin_a[1], 1'b0);
    rd(RA_STAT, a, b); check("R12 status ch1", a, 8'h01);
    rd(RA_C1L, a, b);
    rd(RA_STAT, a, b); check("R8 cleared", a, 8'h00);

    // R5 high-byte rewrite suspends matching
    wr(RA_CTLA, 8'h05);
    c = count_a + 16'd8;
    wr(RA_C1H, c[15:8]);
    wr(RA_C1L, c[7:0]);
    wr(RA_C1H, c[15:8]);
    stray = 1'b0;
    for (int n = 0; n < 48; n++) begin
      @(negedge clk);
      if (irq_a) stray = 1'b1;
    end
    check("R5 suspended", {stray, 15'd0, count_a > c}, {1'b0, 15'd0, 1'b1});
    c2 = count_a + 16'd6;
    wr(RA_C1L, c2[7:0]);
    wait_irq(seen);
    check("R5 rearmed by low byte", {15'd0, seen, count_a}, {15'd0, 1'b1, c[15:8], c2[7:0]});
    rd(RA_STAT, a, b);
    rd(RA_C1L, a, b);

    // R7 flag without interrupt enable; R8 low access alone keeps flag
    wr(RA_CTLA, 8'h00);
    c = count_a + 16'd6;
    wr(RA_C1H, c[15:8]);
    wr(RA_C1L, c[7:0]);
    repeat (30) @(negedge clk);
    check("R7 irq gated", irq_a, 1'b0);
    rd(RA_C1L, a, b);
    wr(RA_CTLA, 8'h04);
    check("R8 flag kept without status read (R7 irq)", irq_a, 1'b1);
    rd(RA_STAT, a, b); check("R7 flag set", a, 8'h01);
    rd(RA_C1L, a, b);
    rd(RA_STAT, a, b);
    check("R8 cleared after sequence", {a, 7'd0, irq_a}, 16'd0);

    // R9 / R10 force
    wr(RA_CTLB, 8'h03);
    wr(RA_CTLA, 8'h2C);
    check("R9 force ch1", pin_a, 2'b01);
    rd(RA_STAT, a, b);
    check("R9 no flag no irq", {a, 7'd0, irq_a}, 16'd0);
    rd(RA_CTLA, a, b); check("R9 force bits read 0", a, 8'h24);
    wr(RA_CTLA, 8'h54);
    check("R9 force ch2 only", pin_a, 2'b11);
    wr(RA_CTLB, 8'h07);
    wr(RA_CTLA, 8'h1C);
    check("R10 single-pulse blocks force", pin_a, 2'b11);
    wr(RA_CTLB, 8'h0B);
    wr(RA_CTLA, 8'h1C);
    check("R10 pulse-width blocks force", pin_a, 2'b11);
    wr(RA_CTLB, 8'h03);
    wr(RA_CTLA, 8'h1C);
    check("R9 force both low", pin_a, 2'b00);
    check("R9 irq quiet", irq_a, 1'b0);

    // R11 write-only channel 2
    wr(RA_C2H, 8'hA5);
    wr(RA_C2L, 8'h3C);
    rd(RA_C2H, a, b); check("R11 c2 high", {a, b}, 16'hA500);
    rd(RA_C2L, a, b); check("R11 c2 low", {a, b}, 16'h3C00);
    rd(RA_C1H, a, b); check("R11 c1 readable", a, b);

    // sweep over rates, channels and distances
    for (int sel = 0; sel < 4; sel++) begin
      ext_run = (sel == 3);
      wr(RA_CTLA, {6'b000001, 2'(sel)});
      case (sel)
        0: measure(2);
        1: measure(4);
        2: measure(8);
        default: measure(3);
      endcase
      for (int ch = 0; ch < 2; ch++) begin
        for (int k = 4; k < 7; k++) begin
          run_case(sel, ch, k);
        end
      end
    end
    ext_run = 1'b0;

    finish_run();
  end
endmodule